// File: doc/BRIEF.md
# Indexed-Register Watchdog Timer

This block is a watchdog timer whose registers are all reached through a pair of byte-wide I/O ports. A write to port offset 0 latches a register index. A read or write at offset 1 then accesses the register at that index. Software programs a 24-bit timeout as three bytes, picks the expiry action, and sets an enable bit. It must then keep restarting the count with a reload bit before the timer runs out.

Counting advances only on cycles where the `tick_en` input is high. That strobe is meant to arrive at 32768 Hz, so the largest timeout of 2^24 ticks lasts 512 seconds. A programmed value N gives N+1 ticks per period. When a period ends, the block pulses one of two request outputs, system reset or non-maskable interrupt, as the signal-select register directs. It also sets a sticky fired flag. The fired flag is not cleared by the block reset, so software can see after a restart that the watchdog caused it.

Top module: `wdt_index_port`

## Requirements
- R1: A write at port offset 0 (`io_addr`=0) latches the register index. A read at offset 0 returns that index. Read data appears on `io_rdata` on the cycle after the read strobe and holds until the next read.
- R2: Index 0x37 (control), 0x38 (signal select), 0x39 / 0x3A / 0x3B (timeout bits 7:0 / 15:8 / 23:16) are written and read back as full bytes through offset 1.
- R3: Reading any index other than 0x37 to 0x3C returns 0x00. Writing such an index changes no register.
- R4: Bit 6 of index 0x37 enables counting. A write that takes it from 0 to 1 loads the counter from the timeout. While it is 0 the counter holds and neither request output is asserted.
- R5: With timeout value N, an expiry occurs on the (N+1)-th `tick_en` cycle after a load. The counter then reloads, so expiries repeat every N+1 ticks.
- R6: Writing 1 to bit 6 of index 0x3C restarts the count from the timeout. This bit always reads back as 0.
- R7: Bit 7 of index 0x3C is the fired flag. It is set on every expiry and stays set. A write to 0x3C with bit 7 at 0 clears it, while a write with bit 7 at 1 leaves it unchanged. The block reset does not clear it.
- R8: On expiry the block asserts one output for one clock, on the cycle after the terminal tick. Signal-select bits 7:4 equal to 0xD pulse `sys_rst_req`. Bits 7:4 equal to 0xC pulse `nmi_req`. Any other value asserts neither output but still sets the fired flag.
- R9: After reset, every register except the fired flag reads 0x00, and both request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | Port write strobe |
| io_rd | input | 1 | Port read strobe |
| io_addr | input | 1 | Port offset: 0 = index, 1 = data |
| io_wdata | input | DATA_W | Write data |
| io_rdata | output | DATA_W | Registered read data |
| tick_en | input | 1 | Count strobe (32768 Hz) |
| sys_rst_req | output | 1 | One-clock system reset request |
| nmi_req | output | 1 | One-clock NMI request |

## Verification
Read data is due one cycle after the read strobe. The bench records each expected byte in a queue as the read is issued, and a monitor compares it at the falling edge after the next rising edge. A request pulse is due one cycle after the terminal tick. The tick task holds each strobe for one cycle and then idles one cycle, so every pulse is counted at a falling edge before the next strobe. The bench then compares the pulse counts after exactly N and exactly N+1 ticks.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] IDX_CTRL  = 8'h37;
  localparam logic [7:0] IDX_SEL   = 8'h38;
  localparam logic [7:0] IDX_TMO0  = 8'h39;
  localparam logic [7:0] IDX_CTRL1 = 8'h3C;

  localparam int EN_BIT     = 6;
  localparam int RELOAD_BIT = 6;
  localparam int FIRED_BIT  = 7;

  localparam logic [3:0] SEL_NMI = 4'hC;
  localparam logic [3:0] SEL_RST = 4'hD;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_NMI  = 2'd1,
    ACT_RST  = 2'd2
  } act_e;
endpackage

// File: rtl/wdt_port_decode.sv
module wdt_port_decode #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic          io_addr,
  input  logic [DW-1:0] io_wdata,
  input  logic [DW-1:0] rf_rdata,
  output logic [DW-1:0] idx_o,
  output logic          rf_we_o,
  output logic [DW-1:0] io_rdata
);
  logic [DW-1:0] idx_q;
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (io_wr && !io_addr) idx_q <= io_wdata;
      if (io_rd) rdata_q <= io_addr ? rf_rdata : idx_q;
    end
  end

  assign idx_o    = idx_q;
  assign rf_we_o  = io_wr && io_addr;
  assign io_rdata = rdata_q;

  // R1: index latched from offset-0 write
  assert_index_latch_R1: assert property (@(posedge clk) disable iff (rst)
    (io_wr && !io_addr) |=> (idx_q == $past(io_wdata)));
  // R1: read data holds between reads
  assert_rdata_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (!io_rd && !$past(rst)) |=> $stable(io_rdata));
endmodule

// File: rtl/wdt_regfile.sv
module wdt_regfile
  import wdt_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_i,
  input  logic [DW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          expire_i,
  output logic [DW-1:0] rdata_o,
  output logic          en_o,
  output act_e          act_o,
  output logic [CW-1:0] tmo_o,
  output logic          load_o
);
  localparam int NB = CW / DW;

  logic [DW-1:0] ctrl_q;
  logic [DW-1:0] sel_q;
  logic [DW-1:0] tmo_q [NB];
  logic [DW-3:0] ctrl1_lo_q;
  logic          fired_q = 1'b0;
  logic [NB-1:0] tmo_hit;

  logic wr_ctrl, wr_sel, wr_ctrl1;
  assign wr_ctrl  = we_i && (idx_i == IDX_CTRL);
  assign wr_sel   = we_i && (idx_i == IDX_SEL);
  assign wr_ctrl1 = we_i && (idx_i == IDX_CTRL1);

  for (genvar g = 0; g < NB; g++) begin : g_tmo
    assign tmo_hit[g] = we_i && (idx_i == IDX_TMO0 + 8'(g));
    assign tmo_o[g*DW +: DW] = tmo_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      sel_q      <= '0;
      ctrl1_lo_q <= '0;
      for (int i = 0; i < NB; i++) tmo_q[i] <= '0;
    end else begin
      if (wr_ctrl)  ctrl_q     <= wdata_i;
      if (wr_sel)   sel_q      <= wdata_i;
      if (wr_ctrl1) ctrl1_lo_q <= wdata_i[DW-3:0];
      for (int i = 0; i < NB; i++)
        if (tmo_hit[i]) tmo_q[i] <= wdata_i;
    end
  end

  // Sticky expiry flag: survives reset, cleared only by a register write.
  always_ff @(posedge clk) begin
    if (expire_i)                           fired_q <= 1'b1;
    else if (wr_ctrl1 && !wdata_i[FIRED_BIT]) fired_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    if (idx_i == IDX_CTRL)  rdata_o = ctrl_q;
    if (idx_i == IDX_SEL)   rdata_o = sel_q;
    if (idx_i == IDX_CTRL1) rdata_o = {fired_q, 1'b0, ctrl1_lo_q};
    for (int i = 0; i < NB; i++)
      if (idx_i == IDX_TMO0 + 8'(i)) rdata_o = tmo_q[i];
  end

  always_comb begin
    case (sel_q[DW-1:DW-4])
      SEL_NMI: act_o = ACT_NMI;
      SEL_RST: act_o = ACT_RST;
      default: act_o = ACT_NONE;
    endcase
  end

  assign en_o   = ctrl_q[EN_BIT];
  assign load_o = (wr_ctrl && wdata_i[EN_BIT] && !ctrl_q[EN_BIT]) ||
                  (wr_ctrl1 && wdata_i[RELOAD_BIT]);

  // R7: expiry sets the flag
  assert_fired_set_R7: assert property (@(posedge clk) disable iff (rst)
    expire_i |=> fired_q);
  // R7: flag holds unless cleared by a write with bit 7 low
  assert_fired_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (fired_q && !(wr_ctrl1 && !wdata_i[FIRED_BIT])) |=> fired_q);
  // R3: a write to an unimplemented index leaves the control byte unchanged
  assert_unimpl_write_R3: assert property (@(posedge clk) disable iff (rst)
    (we_i && !wr_ctrl) |=> $stable(ctrl_q));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [CW-1:0] tmo_i,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;
  logic          at_zero;

  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)                  cnt_q <= '0;
    else if (load_i)          cnt_q <= tmo_i;
    else if (en_i && tick_i)  cnt_q <= at_zero ? tmo_i : cnt_q - 1'b1;
  end

  assign expire_o = en_i && tick_i && !load_i && at_zero;

  // R4: disabled counter holds
  assert_hold_disabled_R4: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !load_i) |=> $stable(cnt_q));
  // R6: a reload or enable edge loads the timeout
  assert_load_value_R6: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cnt_q == $past(tmo_i)));
  // R5: expiry restarts the period from the timeout
  assert_period_restart_R5: assert property (@(posedge clk) disable iff (rst)
    expire_o |=> (cnt_q == $past(tmo_i)));
endmodule

// File: rtl/wdt_steer.sv
module wdt_steer
  import wdt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic expire_i,
  input  act_e act_i,
  output logic rst_req_o,
  output logic nmi_req_o
);
  logic rst_q, nmi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_q <= 1'b0;
      nmi_q <= 1'b0;
    end else begin
      rst_q <= expire_i && (act_i == ACT_RST);
      nmi_q <= expire_i && (act_i == ACT_NMI);
    end
  end

  assign rst_req_o = rst_q;
  assign nmi_req_o = nmi_q;

  // R8: never both requests at once
  assert_onehot_req_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rst_q, nmi_q}));
  // R8: a request only follows an expiry
  assert_req_cause_R8: assert property (@(posedge clk) disable iff (rst)
    (rst_q || nmi_q) |-> $past(expire_i));
endmodule

// File: rtl/wdt_index_port.sv
module wdt_index_port
  import wdt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic              io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  input  logic              tick_en,
  output logic              sys_rst_req,
  output logic              nmi_req
);
  logic [DATA_W-1:0] idx;
  logic [DATA_W-1:0] rf_rdata;
  logic              rf_we;
  logic              en, load, expire;
  logic [CNT_W-1:0]  tmo;
  act_e              act;

  wdt_port_decode #(.DW(DATA_W)) u_decode (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .rf_rdata(rf_rdata), .idx_o(idx), .rf_we_o(rf_we),
    .io_rdata(io_rdata)
  );

  wdt_regfile #(.DW(DATA_W), .CW(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .we_i(rf_we), .idx_i(idx), .wdata_i(io_wdata),
    .expire_i(expire), .rdata_o(rf_rdata), .en_o(en), .act_o(act),
    .tmo_o(tmo), .load_o(load)
  );

  wdt_counter #(.CW(CNT_W)) u_count (
    .clk(clk), .rst(rst), .en_i(en), .tick_i(tick_en), .load_i(load),
    .tmo_i(tmo), .expire_o(expire)
  );

  wdt_steer u_steer (
    .clk(clk), .rst(rst), .expire_i(expire), .act_i(act),
    .rst_req_o(sys_rst_req), .nmi_req_o(nmi_req)
  );

  // R4: no request while disabled
  assert_quiet_disabled_R4: assert property (@(posedge clk) disable iff (rst)
    (!en && !$past(en)) |-> !(sys_rst_req || nmi_req));
endmodule

// File: tb/wdt_index_port_tb_top.sv
module wdt_index_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       io_wr = 1'b0, io_rd = 1'b0, io_addr = 1'b0, tick_en = 1'b0;
  logic [7:0] io_wdata = 8'h00;
  logic [7:0] io_rdata;
  logic       sys_rst_req, nmi_req;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_index_port dut_i (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .tick_en(tick_en),
    .sys_rst_req(sys_rst_req), .nmi_req(nmi_req)
  );

  int checks = 0, fails = 0, rst_pulses = 0, nmi_pulses = 0;
  bit done = 0, rd_d = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: read result due one cycle after the strobe; pulses counted per cycle.
  always @(posedge clk) rd_d <= io_rd;
  always @(negedge clk) begin
    if (sys_rst_req) rst_pulses++;
    if (nmi_req) nmi_pulses++;
    if (rd_d && exp_q.size() > 0) check(tag_q.pop_front(), io_rdata, exp_q.pop_front());
  end

  task automatic wr(bit a, logic [7:0] d);
    io_wr = 1; io_addr = a; io_wdata = d;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic rd(bit a, logic [7:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    io_rd = 1; io_addr = a;
    @(negedge clk); io_rd = 0;
    @(negedge clk);
  endtask

  task automatic reg_wr(logic [7:0] idx, logic [7:0] d);
    wr(0, idx); wr(1, d);
  endtask

  task automatic reg_rd(logic [7:0] idx, logic [7:0] exp, string tag);
    wr(0, idx); rd(1, exp, tag);
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1; @(negedge clk); tick_en = 0; @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9 reset state
    check("R9 rst_req after reset", sys_rst_req, 0);
    check("R9 nmi_req after reset", nmi_req, 0);
    reg_rd(8'h37, 8'h00, "R9 ctrl reset");
    reg_rd(8'h38, 8'h00, "R9 select reset");
    reg_rd(8'h3C, 8'h00, "R9 ctrl1 reset");
    // R1 index port
    wr(0, 8'h39);
    rd(0, 8'h39, "R1 index readback");
    // R2 timeout bytes
    reg_wr(8'h39, 8'h05);
    reg_wr(8'h3A, 8'h12);
    reg_wr(8'h3B, 8'hA7);
    reg_rd(8'h39, 8'h05, "R2 timeout low");
    reg_rd(8'h3A, 8'h12, "R2 timeout mid");
    reg_rd(8'h3B, 8'hA7, "R2 timeout high");
    reg_wr(8'h3A, 8'h00);
    reg_wr(8'h3B, 8'h00);
    // R3 unimplemented indices
    reg_wr(8'h50, 8'hFF);
    reg_wr(8'h3D, 8'hFF);
    reg_rd(8'h50, 8'h00, "R3 unimpl read 0x50");
    reg_rd(8'h36, 8'h00, "R3 unimpl read 0x36");
    reg_rd(8'h37, 8'h00, "R3 ctrl untouched");
    // R8 select reset; R4 disabled holds
    reg_wr(8'h38, 8'hD0);
    reg_rd(8'h38, 8'hD0, "R2 select readback");
    tick(10);
    check("R4 no pulse while disabled", rst_pulses + nmi_pulses, 0);
    reg_wr(8'h37, 8'h40);
    reg_rd(8'h37, 8'h40, "R2 ctrl readback");
    tick(5);
    check("R5 no expiry after N ticks", rst_pulses, 0);
    tick(1);
    check("R5 R8 reset pulse after N+1 ticks", rst_pulses, 1);
    check("R8 no nmi on reset select", nmi_pulses, 0);
    reg_rd(8'h3C, 8'h80, "R7 fired set");
    tick(6);
    check("R5 periodic expiry", rst_pulses, 2);
    // R7 sticky behaviour
    reg_wr(8'h3C, 8'h80);
    reg_rd(8'h3C, 8'h80, "R7 write 1 keeps flag");
    reg_wr(8'h3C, 8'h00);
    reg_rd(8'h3C, 8'h00, "R7 write 0 clears flag");
    // R6 reload
    tick(3);
    reg_wr(8'h3C, 8'h40);
    reg_rd(8'h3C, 8'h00, "R6 reload reads 0");
    tick(5);
    check("R6 reload restarts period", rst_pulses, 2);
    tick(1);
    check("R6 expiry after reload", rst_pulses, 3);
    reg_wr(8'h3C, 8'hC0);
    reg_rd(8'h3C, 8'h80, "R7 reload with bit7 set keeps flag");
    // R8 NMI select
    reg_wr(8'h38, 8'hC0);
    tick(6);
    check("R8 nmi pulse", nmi_pulses, 1);
    check("R8 no reset on nmi select", rst_pulses, 3);
    // R8 other select
    reg_wr(8'h3C, 8'h00);
    reg_wr(8'h38, 8'h70);
    tick(6);
    check("R8 other select: no pulses", rst_pulses + nmi_pulses, 4);
    reg_rd(8'h3C, 8'h80, "R8 other select sets fired");
    // R4 disable, then enable edge loads new timeout
    reg_wr(8'h37, 8'h00);
    reg_wr(8'h38, 8'hD0);
    tick(20);
    check("R4 disabled no pulses", rst_pulses + nmi_pulses, 4);
    reg_wr(8'h39, 8'h02);
    reg_wr(8'h37, 8'h40);
    tick(2);
    check("R4 enable edge load, before expiry", rst_pulses, 3);
    tick(1);
    check("R4 enable edge load, expiry", rst_pulses, 4);
    // R9 / R7 fired survives reset
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk); rst = 0;
    @(negedge clk);
    reg_rd(8'h3C, 8'h80, "R7 fired survives reset");
    reg_rd(8'h37, 8'h00, "R9 ctrl cleared by reset");
    reg_rd(8'h39, 8'h00, "R9 timeout cleared by reset");
    tick(4);
    check("R9 no pulses after reset", rst_pulses + nmi_pulses, 5);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end
endmodule